// File: doc/BRIEF.md
# Luma Byte Capture for a 4:2:2 Sensor Stream

This block sits on the parallel byte bus of an image sensor and runs on the sensor's pixel clock. The sensor sends each line as repeating groups of four bytes, blue-difference chroma, luma, red-difference chroma, luma. Each luma byte belongs to one pixel, and two neighbouring pixels share one pair of chroma bytes. The block keeps only the luma bytes and produces an 8-bit grayscale stream, one sample per pixel, with a single-cycle valid strobe.

A byte counts only while the frame-blanking signal (vsync) is low and the line-active signal (href) is high. A one-bit phase register toggles on every qualified clock edge, which selects the second byte of each pair. The phase returns to the chroma position whenever a line is not active, so each line starts on a chroma byte even when the previous line had an odd length.

Column and line counters go out with each sample so that downstream logic can address a frame buffer. A one-cycle frame-start pulse marks the end of vertical blanking.

Top module: `luma_capture`

## Requirements
- R1: No sample is captured while vsync is high, whatever href and the data bus carry.
- R2: No sample is captured while href is low. Bytes presented during the gaps between lines have no effect on the output stream.
- R3: Within an active line, counting bytes from 1, each even-numbered byte (2nd, 4th, ...) is captured and each odd-numbered byte is discarded. The captured value appears on y_data unchanged.
- R4: The byte phase restarts at the first byte of every line. After a line with an odd number of bytes, the next line's first byte is still discarded as chroma.
- R5: y_valid is high for exactly one pixel-clock cycle for each captured byte, one clock edge after the edge that sampled that byte. It is never high on two consecutive cycles.
- R6: x_pos, presented with each sample, is the pixel's 0-based column in its line: 0 for the first luma byte, then rising by one per sample.
- R7: A line yields at most MAX_COLS samples. Luma bytes after that count are dropped with no strobe, and x_pos never reaches MAX_COLS.
- R8: y_pos is the 0-based line index within the frame. It rises by one on the clock edge that first samples href low after href was high with vsync low.
- R9: y_pos reads 0 after any clock edge that samples vsync high.
- R10: frame_start pulses high for one cycle, one clock edge after the first edge that samples vsync low following a high.
- R11: After synchronous reset, y_valid, frame_start, y_data, x_pos and y_pos are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Sensor pixel clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| vsync | input | 1 | Vertical blanking, high between frames |
| href | input | 1 | Line active, high while line bytes are on the bus |
| pix_data | input | DATA_W | Sensor byte bus |
| y_data | output | DATA_W | Captured luma sample |
| y_valid | output | 1 | One-cycle strobe qualifying y_data and x_pos |
| x_pos | output | $clog2(MAX_COLS+1) | Column of the current sample |
| y_pos | output | $clog2(MAX_ROWS+1) | Line index within the frame |
| frame_start | output | 1 | One-cycle pulse when vertical blanking ends |

## Verification
The sample outputs (y_data, y_valid, x_pos) are due one rising edge after the edge that sees the luma byte. frame_start is due one edge after the edge that first sees vsync low. y_pos changes on the same edge that samples the href fall or the vsync-high level. The driver changes inputs only at falling edges and pushes each expected sample in the cycle where its byte is on the bus. The monitor samples the inputs at each rising edge, reads the outputs one time unit later, and requires the strobe to appear exactly when the queue holds an item. A strobe that comes early, comes late or is missing therefore fails in the cycle it goes wrong.

// File: rtl/luma_cap_pkg.sv
package luma_cap_pkg;

    typedef enum logic {
        PH_CHROMA = 1'b0,
        PH_LUMA   = 1'b1
    } phase_t;

    typedef struct packed {
        logic active;       // byte on the bus belongs to a line
        logic line_end;     // href has just dropped inside a frame
        logic frame_begin;  // vsync has just dropped
        logic frame_blank;  // vertical blanking in progress
    } qual_t;

    function automatic phase_t next_phase(phase_t cur, logic active);
        if (!active)
            return PH_CHROMA;
        return (cur == PH_CHROMA) ? PH_LUMA : PH_CHROMA;
    endfunction

    function automatic logic below_limit(int unsigned count, int unsigned limit);
        return count < limit;
    endfunction

endpackage

// File: rtl/sync_qualifier.sv
module sync_qualifier
    import luma_cap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  vsync,
    input  logic  href,
    output qual_t qual
);
    logic href_q;
    logic vs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            href_q <= 1'b0;
            vs_q   <= 1'b0;
        end else begin
            href_q <= href;
            vs_q   <= vsync;
        end
    end

    always_comb begin
        qual.active      = href & ~vsync;
        qual.line_end    = href_q & ~href & ~vsync;
        qual.frame_begin = vs_q & ~vsync;
        qual.frame_blank = vsync;
    end
endmodule

// File: rtl/byte_phase.sv
module byte_phase
    import luma_cap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic take
);
    phase_t phase;

    always_ff @(posedge clk) begin
        if (rst)
            phase <= PH_CHROMA;
        else
            phase <= next_phase(phase, active);
    end

    assign take = active & (phase == PH_LUMA);
endmodule

// File: rtl/pos_counters.sv
module pos_counters
    import luma_cap_pkg::*;
#(
    parameter int MAX_COLS = 640,
    parameter int MAX_ROWS = 480,
    localparam int XW = $clog2(MAX_COLS + 1),
    localparam int YW = $clog2(MAX_ROWS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  qual_t         qual,
    input  logic          take,
    output logic [XW-1:0] x_cur,
    output logic [YW-1:0] y_cur,
    output logic          room
);
    assign room = below_limit(int'(x_cur), MAX_COLS);

    always_ff @(posedge clk) begin
        if (rst)
            x_cur <= '0;
        else if (!qual.active)
            x_cur <= '0;
        else if (take && room)
            x_cur <= x_cur + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            y_cur <= '0;
        else if (qual.frame_blank)
            y_cur <= '0;
        else if (qual.line_end)
            y_cur <= y_cur + 1'b1;
    end
endmodule

// File: rtl/luma_out.sv
module luma_out #(
    parameter int DATA_W = 8,
    parameter int XW     = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              fs_in,
    input  logic [DATA_W-1:0] din,
    input  logic [XW-1:0]     x_in,
    output logic [DATA_W-1:0] y_data,
    output logic              y_valid,
    output logic [XW-1:0]     x_pos,
    output logic              frame_start
);
    always_ff @(posedge clk) begin
        if (rst) begin
            y_data      <= '0;
            y_valid     <= 1'b0;
            x_pos       <= '0;
            frame_start <= 1'b0;
        end else begin
            y_valid     <= capture;
            frame_start <= fs_in;
            if (capture) begin
                y_data <= din;
                x_pos  <= x_in;
            end
        end
    end
endmodule

// File: rtl/luma_capture.sv
module luma_capture
    import luma_cap_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MAX_COLS = 640,
    parameter int MAX_ROWS = 480,
    localparam int XW = $clog2(MAX_COLS + 1),
    localparam int YW = $clog2(MAX_ROWS + 1)
) (
    input  logic              pclk,
    input  logic              rst,
    input  logic              vsync,
    input  logic              href,
    input  logic [DATA_W-1:0] pix_data,
    output logic [DATA_W-1:0] y_data,
    output logic              y_valid,
    output logic [XW-1:0]     x_pos,
    output logic [YW-1:0]     y_pos,
    output logic              frame_start
);
    qual_t         qual;
    logic          take;
    logic          room;
    logic [XW-1:0] x_cur;

    sync_qualifier u_qual (
        .clk   (pclk),
        .rst   (rst),
        .vsync (vsync),
        .href  (href),
        .qual  (qual)
    );

    byte_phase u_phase (
        .clk    (pclk),
        .rst    (rst),
        .active (qual.active),
        .take   (take)
    );

    pos_counters #(
        .MAX_COLS (MAX_COLS),
        .MAX_ROWS (MAX_ROWS)
    ) u_pos (
        .clk   (pclk),
        .rst   (rst),
        .qual  (qual),
        .take  (take),
        .x_cur (x_cur),
        .y_cur (y_pos),
        .room  (room)
    );

    luma_out #(
        .DATA_W (DATA_W),
        .XW     (XW)
    ) u_out (
        .clk         (pclk),
        .rst         (rst),
        .capture     (take & room),
        .fs_in       (qual.frame_begin),
        .din         (pix_data),
        .x_in        (x_cur),
        .y_data      (y_data),
        .y_valid     (y_valid),
        .x_pos       (x_pos),
        .frame_start (frame_start)
    );
endmodule

// File: rtl/luma_capture_chk.sv
module luma_capture_chk #(
    parameter int DATA_W   = 8,
    parameter int MAX_COLS = 640,
    parameter int MAX_ROWS = 480,
    localparam int XW = $clog2(MAX_COLS + 1),
    localparam int YW = $clog2(MAX_ROWS + 1)
) (
    input logic              pclk,
    input logic              rst,
    input logic              vsync,
    input logic              href,
    input logic [DATA_W-1:0] y_data,
    input logic              y_valid,
    input logic [XW-1:0]     x_pos,
    input logic [YW-1:0]     y_pos,
    input logic              frame_start
);
    AST_STROBE_IN_LINE: assert property (@(posedge pclk) disable iff (rst)
        y_valid |-> ($past(href) && !$past(vsync))); // R1

    AST_STROBE_SINGLE: assert property (@(posedge pclk) disable iff (rst)
        y_valid |=> !y_valid); // R5

    AST_COLUMN_BOUND: assert property (@(posedge pclk) disable iff (rst)
        y_valid |-> (int'(x_pos) < MAX_COLS)); // R7

    AST_LINE_CLEARED: assert property (@(posedge pclk) disable iff (rst)
        $past(vsync) |-> (y_pos == '0)); // R9

    AST_FRAME_EDGE: assert property (@(posedge pclk) disable iff (rst)
        frame_start |-> ($past(vsync, 2) && !$past(vsync))); // R10

    AST_FRAME_SINGLE: assert property (@(posedge pclk) disable iff (rst)
        frame_start |=> !frame_start); // R10

    logic unused_data;
    assign unused_data = ^y_data;
endmodule

bind luma_capture luma_capture_chk #(
    .DATA_W   (DATA_W),
    .MAX_COLS (MAX_COLS),
    .MAX_ROWS (MAX_ROWS)
) u_chk (
    .pclk        (pclk),
    .rst         (rst),
    .vsync       (vsync),
    .href        (href),
    .y_data      (y_data),
    .y_valid     (y_valid),
    .x_pos       (x_pos),
    .y_pos       (y_pos),
    .frame_start (frame_start)
);

// File: tb/tb_luma_capture.sv
module tb_luma_capture;
    localparam int CLK_PERIOD = 10;
    localparam int TB_COLS    = 6;
    localparam int TB_ROWS    = 480;
    localparam int XW = $clog2(TB_COLS + 1);
    localparam int YW = $clog2(TB_ROWS + 1);

    logic          pclk = 1'b0;
    logic          rst;
    logic          vsync;
    logic          href;
    logic [7:0]    pix_data;
    logic [7:0]    y_data;
    logic          y_valid;
    logic [XW-1:0] x_pos;
    logic [YW-1:0] y_pos;
    logic          frame_start;

    typedef struct {
        logic [7:0] d;
        int         x;
        int         y;
    } exp_t;

    exp_t exp_q[$];
    int   checks   = 0;
    int   errors   = 0;
    int   cur_line = 0;
    bit   mon_en   = 0;
    bit   done     = 0;

    always #(CLK_PERIOD/2) pclk = ~pclk;

    luma_capture #(
        .DATA_W   (8),
        .MAX_COLS (TB_COLS),
        .MAX_ROWS (TB_ROWS)
    ) dut (
        .pclk        (pclk),
        .rst         (rst),
        .vsync       (vsync),
        .href        (href),
        .pix_data    (pix_data),
        .y_data      (y_data),
        .y_valid     (y_valid),
        .x_pos       (x_pos),
        .y_pos       (y_pos),
        .frame_start (frame_start)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic tick(input logic v, input logic h, input logic [7:0] d);
        @(negedge pclk);
        vsync    = v;
        href     = h;
        pix_data = d;
    endtask

    // One line of n bytes; luma at even byte numbers counted from 1 (R3, R4, R6, R7)
    task automatic send_line(input int n, input int base, input int gap);
        for (int i = 0; i < n; i++) begin
            tick(1'b0, 1'b1, 8'(base + i));
            if ((i % 2 == 1) && (i / 2 < TB_COLS))
                exp_q.push_back('{d: 8'(base + i), x: i / 2, y: cur_line});
        end
        // gap bytes on the bus with href low must be ignored (R2)
        for (int g = 0; g < gap; g++)
            tick(1'b0, 1'b0, 8'hE0 + 8'(g));
        cur_line++;
    endtask

    // vertical blanking, href held high with data to show it is ignored (R1)
    task automatic blank(input int n);
        for (int i = 0; i < n; i++)
            tick(1'b1, 1'b1, 8'hA0 + 8'(i));
        cur_line = 0;
    endtask

    // monitor / scoreboard
    initial begin
        logic prev_vs;
        logic s_vs;
        prev_vs = 1'b0;
        forever begin
            @(posedge pclk);
            s_vs = vsync;
            #1;
            if (mon_en) begin
                check(y_valid == (exp_q.size() != 0),
                      "R1/R2/R3/R4/R5/R7 strobe timing", int'(y_valid), int'(exp_q.size() != 0));
                if (y_valid && exp_q.size() != 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(y_data == e.d, "R3 luma value", int'(y_data), int'(e.d));
                    check(int'(x_pos) == e.x, "R6 column", int'(x_pos), e.x);
                    check(int'(y_pos) == e.y, "R8 line index", int'(y_pos), e.y);
                end else if (!y_valid && exp_q.size() != 0) begin
                    void'(exp_q.pop_front());
                end
                check(frame_start == (prev_vs && !s_vs), "R10 frame start",
                      int'(frame_start), int'(prev_vs && !s_vs));
                if (s_vs)
                    check(y_pos == '0, "R9 line clear", int'(y_pos), 0);
                prev_vs = s_vs;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        rst = 1'b1; vsync = 1'b0; href = 1'b0; pix_data = 8'h00;
        repeat (4) @(negedge pclk);
        rst = 1'b0;
        @(negedge pclk);
        // R11 reset state
        check(y_valid == 1'b0,    "R11 y_valid", int'(y_valid), 0);
        check(frame_start == 1'b0, "R11 frame_start", int'(frame_start), 0);
        check(y_data == 8'h00,    "R11 y_data", int'(y_data), 0);
        check(x_pos == '0,        "R11 x_pos", int'(x_pos), 0);
        check(y_pos == '0,        "R11 y_pos", int'(y_pos), 0);
        mon_en = 1;

        blank(3);                 // R1, then falling vsync for R10
        send_line(8, 8'h10, 2);   // R3, R6
        send_line(7, 8'h30, 3);   // odd length (R4)
        send_line(6, 8'h50, 1);   // follows the odd line (R4), line 2 (R8)
        send_line(16, 8'h70, 2);  // beyond TB_COLS samples (R7)
        send_line(4, 8'hC0, 4);   // R8
        blank(2);                 // R9, new frame
        send_line(4, 8'h20, 2);   // line index restarts (R9)
        send_line(3, 8'h40, 2);
        tick(1'b0, 1'b0, 8'h00);
        tick(1'b0, 1'b0, 8'h00);
        check(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);
        finish_run();
    end
endmodule